// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Decoder with Byte-Write Array

This block sits behind the clocked control pins of a synchronous burst SRAM. On every rising clock edge it turns three chip selects, two address-start strobes, a burst-advance input and the write controls into one cycle operation. The operations are deselect, read begin, write begin, burst continue and burst suspend. It also turns the write controls into one write strobe per 9-bit lane of an 18-bit word, and applies those strobes to a small parameterized array at the current burst address.

A burst is four words. Each word address is formed from a loaded base and a 2-bit step, in either linear or interleaved order. Read data leaves in one of two ways, chosen by a mode input. In flow-through mode it appears one edge after the read is sampled. In registered (pipelined) mode it appears one edge later than that. A deselect shuts the output drive down one cycle later than a plain pipeline stage would. The output enable gates the bus combinationally and is not sampled by the clock. The bus is modelled as a data vector plus a drive-enable flag; the data vector reads zero when the flag is low.

The two start strobes differ. The processor-side strobe always starts a read. The controller-side strobe starts a write whenever the write controls decode to a write. A write that follows a processor-side start therefore happens in a later continue or suspend cycle, at that cycle's burst address.

Top module: `sbsram_core`

## Requirements
- R1: The device counts as selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A cycle is a deselect (`cyc_op`=0) when it is unselected and a start is requested, either by `ctl_start_n`=0 or by `cpu_start_n`=0 together with `en_a_n`=0.
- R2: `cpu_start_n`=0 while selected gives read begin (`cyc_op`=1) and `wr_lane`=0, whatever the write inputs are. This strobe wins over `ctl_start_n`.
- R3: `ctl_start_n`=0 while selected, in a cycle that R2 does not cover, gives write begin (`cyc_op`=2) when the write decode of R4 is nonzero, and read begin (`cyc_op`=1) otherwise. A begin cycle loads `addr` as the burst base with step 0.
- R4: The write decode works as follows. `wr_all_n`=0 gives both lanes (2'b11). Otherwise, `wr_byte_n`=0 gives the inverse of `lane_sel_n`. Otherwise it gives 2'b00. `wr_lane[0]` covers data bits 8:0 and `wr_lane[1]` covers bits 17:9.
- R5: A cycle that is neither a begin nor a deselect is a continue (`cyc_op`=3) when `adv_n`=0 and a suspend (`cyc_op`=4) when `adv_n`=1. Continue advances the step by one before the access; suspend keeps the address. Inside an active burst, such a cycle writes the R4 lanes at its burst address, or reads when the decode is 2'b00.
- R6: The low two address bits are base+step modulo 4 when `lin_order`=1, and base XOR step when `lin_order`=0. The upper bits stay at the base value.
- R7: With `flow_mode`=1, a read sampled at one edge drives its word after that same edge. With `flow_mode`=0 it drives after the following edge.
- R8: After a deselect sampled at edge N, the drive that would have existed stays on until edge N+1 and is off after it, in both modes. Two deselects in a row always leave the bus undriven.
- R9: `oe_n`=1 forces `bus_en`=0 at once, with no clock edge involved.
- R10: Continue or suspend cycles while no burst is active (after reset or a deselect) neither write nor read: `wr_lane`=0 and no drive follows.
- R11: While in reset and right after it, `bus_en`=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_a_n | input | 1 | Chip select, active low |
| en_b | input | 1 | Chip select, active high |
| en_c_n | input | 1 | Chip select, active low |
| cpu_start_n | input | 1 | Processor-side start strobe, always a read |
| ctl_start_n | input | 1 | Controller-side start strobe, read or write |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write both lanes, active low |
| wr_byte_n | input | 1 | Enables per-lane write selects, active low |
| lane_sel_n | input | 2 | Per-lane write selects, active low |
| addr | input | 6 | Word address, loaded on a begin |
| wdata | input | 18 | Write data, two 9-bit lanes |
| flow_mode | input | 1 | 1 flow-through, 0 registered output |
| lin_order | input | 1 | 1 linear burst order, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| bus_en | output | 1 | Data bus is driven |
| bus_data | output | 18 | Read data, zero when not driven |
| cyc_op | output | 3 | Decoded operation of the current cycle |
| wr_lane | output | 2 | Per-lane write strobes of the current cycle |

## Verification
The bench attacks the processor strobe with the global write held low. A decoder that let the write controls through there would corrupt memory and report write begin. A write in the suspend cycle after a processor start is checked by reading it back; a design that dropped the write, or that wrote at the wrong step, would return the old word. Burst order is checked from base 1, where linear and interleaved orders differ, and both deselect timings are checked in both output modes: a plain pipeline releases the flow-through bus one cycle early. Random traffic with bursts left open across deselects catches continue cycles that write while no burst is active.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [2:0] {
        OP_DESEL    = 3'd0,
        OP_RD_BEGIN = 3'd1,
        OP_WR_BEGIN = 3'd2,
        OP_CONT     = 3'd3,
        OP_SUSP     = 3'd4
    } cyc_op_e;

    // Low two address bits of a burst beat: linear adds, interleaved XORs.
    function automatic logic [1:0] beat_low(input logic [1:0] base,
                                            input logic [1:0] step,
                                            input logic       linear);
        return linear ? (base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/sbsram_cmd_dec.sv
module sbsram_cmd_dec
    import sbsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             en_a_n,
    input  logic             en_b,
    input  logic             en_c_n,
    input  logic             cpu_start_n,
    input  logic             ctl_start_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_sel_n,
    output cyc_op_e          op,
    output logic [LANES-1:0] wr_fn
);

    logic selected;

    always_comb begin
        selected = !en_a_n && en_b && !en_c_n;

        if (!wr_all_n)       wr_fn = '1;
        else if (!wr_byte_n) wr_fn = ~lane_sel_n;
        else                 wr_fn = '0;

        if (!cpu_start_n && !en_a_n)
            op = selected ? OP_RD_BEGIN : OP_DESEL;
        else if (!ctl_start_n)
            op = !selected ? OP_DESEL :
                 (wr_fn != '0) ? OP_WR_BEGIN : OP_RD_BEGIN;
        else
            op = adv_n ? OP_SUSP : OP_CONT;
    end

endmodule

// File: rtl/sbsram_burst_addr.sv
module sbsram_burst_addr
    import sbsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          linear,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] acc_addr
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [1:0]    cnt;
    } burst_t;

    burst_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (load) begin
            b_d.base = addr_in;
            b_d.cnt  = 2'd0;
        end else if (step) begin
            b_d.cnt  = b_q.cnt + 2'd1;
        end
        acc_addr = {b_d.base[AW-1:2], beat_low(b_d.base[1:0], b_d.cnt, linear)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    cpu_start_n,
    input  logic                    ctl_start_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    flow_mode,
    input  logic                    lin_order,
    input  logic                    oe_n,
    output logic                    bus_en,
    output logic [LANES*LANE_W-1:0] bus_data,
    output logic [2:0]              cyc_op,
    output logic [LANES-1:0]        wr_lane
);

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic          active;
        logic          s1_en;
        logic          s1_dsel;
        logic [AW-1:0] s1_addr;
        logic          s2_en;
        logic [DW-1:0] s2_data;
    } core_t;

    core_t st_d, st_q;

    cyc_op_e          op;
    logic [LANES-1:0] wr_fn;
    logic [AW-1:0]    acc_addr;
    logic [DW-1:0]    arr_rdata;
    logic             is_begin, in_burst, burst_act, drive;
    logic [DW-1:0]    drive_data;

    sbsram_cmd_dec #(.LANES(LANES)) dec_i (
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .adv_n(adv_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
        .op(op), .wr_fn(wr_fn)
    );

    sbsram_burst_addr #(.AW(AW)) burst_i (
        .clk(clk), .rst_n(rst_n),
        .load(is_begin), .step(op == OP_CONT && st_q.active),
        .linear(lin_order), .addr_in(addr), .acc_addr(acc_addr)
    );

    sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk(clk), .we(wr_lane), .waddr(acc_addr), .wdata(wdata),
        .raddr(st_q.s1_addr), .rdata(arr_rdata)
    );

    always_comb begin
        is_begin = (op == OP_RD_BEGIN) || (op == OP_WR_BEGIN);
        in_burst = (op == OP_CONT || op == OP_SUSP) && st_q.active;
        wr_lane  = (op == OP_WR_BEGIN || in_burst) ? wr_fn : '0;

        st_d         = st_q;
        st_d.active  = is_begin ? 1'b1 : (op == OP_DESEL) ? 1'b0 : st_q.active;
        st_d.s1_en   = (op == OP_RD_BEGIN) || (in_burst && wr_fn == '0);
        st_d.s1_dsel = (op == OP_DESEL);
        st_d.s1_addr = acc_addr;
        st_d.s2_en   = st_q.s1_en;
        st_d.s2_data = arr_rdata;

        // Flow-through holds the previous word one extra cycle after a deselect.
        if (flow_mode) begin
            drive      = st_q.s1_en || (st_q.s1_dsel && st_q.s2_en);
            drive_data = st_q.s1_en ? arr_rdata : st_q.s2_data;
        end else begin
            drive      = st_q.s2_en;
            drive_data = st_q.s2_data;
        end
        bus_en   = drive && !oe_n;
        bus_data = bus_en ? drive_data : '0;
        cyc_op   = op;
    end

    assign burst_act = st_q.active;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk
    import sbsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_a_n,
    input logic             en_b,
    input logic             en_c_n,
    input logic             cpu_start_n,
    input logic             ctl_start_n,
    input logic             wr_all_n,
    input logic             oe_n,
    input logic [2:0]       cyc_op,
    input logic [LANES-1:0] wr_lane,
    input logic             bus_en,
    input logic             burst_act
);

    logic sel;
    assign sel = !en_a_n && en_b && !en_c_n;

    AST_DESEL_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (((!cpu_start_n && !en_a_n) || !ctl_start_n) && !sel) |-> cyc_op == OP_DESEL); // R1

    AST_CPU_STROBE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_start_n && sel) |-> (cyc_op == OP_RD_BEGIN && wr_lane == '0)); // R2

    AST_GLOBAL_WRITE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_op == OP_WR_BEGIN && !wr_all_n) |-> wr_lane == '1); // R4

    AST_DCD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cyc_op) == OP_DESEL && $past(cyc_op, 2) == OP_DESEL) |-> !bus_en); // R8

    AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !bus_en); // R9

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_act && (cyc_op == OP_CONT || cyc_op == OP_SUSP)) |-> wr_lane == '0); // R10

endmodule

bind sbsram_core sbsram_core_chk #(.LANES(LANES)) chk_i (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .wr_all_n(wr_all_n),
    .oe_n(oe_n), .cyc_op(cyc_op), .wr_lane(wr_lane), .bus_en(bus_en),
    .burst_act(burst_act)
);

// File: tb/sbsram_core_tb.sv
module sbsram_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a_n, en_b, en_c_n, cpu_start_n, ctl_start_n, adv_n;
    logic wr_all_n, wr_byte_n, flow_mode, lin_order, oe_n;
    logic [1:0] lane_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic bus_en;
    logic [DW-1:0] bus_data;
    logic [2:0] cyc_op;
    logic [1:0] wr_lane;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbsram_core dut_i (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .adv_n(adv_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
        .addr(addr), .wdata(wdata), .flow_mode(flow_mode), .lin_order(lin_order),
        .oe_n(oe_n), .bus_en(bus_en), .bus_data(bus_data), .cyc_op(cyc_op),
        .wr_lane(wr_lane)
    );

    // Reference state, built from the requirements
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_base, m_p1_addr;
    logic [1:0]    m_cnt;
    logic          m_act, m_p1_en, m_p1_dsel, m_p2_en;
    logic [DW-1:0] m_p2_data;

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 18'h1357) ^ 18'h2A5A5;
    endfunction

    function automatic logic [1:0] f_wfn();
        if (!wr_all_n) return 2'b11;
        if (!wr_byte_n) return ~lane_sel_n;
        return 2'b00;
    endfunction

    function automatic logic [2:0] f_op();
        logic sel;
        sel = !en_a_n && en_b && !en_c_n;
        if (!cpu_start_n && !en_a_n) return sel ? 3'd1 : 3'd0;
        if (!ctl_start_n) return !sel ? 3'd0 : (f_wfn() != 2'b00) ? 3'd2 : 3'd1;
        return adv_n ? 3'd4 : 3'd3;
    endfunction

    function automatic logic [1:0] f_lane();
        logic [2:0] o;
        o = f_op();
        if (o == 3'd2 || ((o == 3'd3 || o == 3'd4) && m_act)) return f_wfn();
        return 2'b00;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_base = '0; m_cnt = '0; m_act = 1'b0; m_p1_en = 1'b0; m_p1_dsel = 1'b0;
        m_p1_addr = '0; m_p2_en = 1'b0; m_p2_data = '0;
    endtask

    task automatic model_edge();
        logic [2:0] o;
        logic [1:0] ln;
        logic [AW-1:0] acc;
        logic [DW-1:0] newp2;
        logic cont_like;
        o = f_op();
        ln = f_lane();
        cont_like = (o == 3'd3 || o == 3'd4) && m_act;
        if (o == 3'd1 || o == 3'd2) begin m_base = addr; m_cnt = 2'd0; end
        else if (o == 3'd3 && m_act) m_cnt = m_cnt + 2'd1;
        acc = {m_base[AW-1:2], lin_order ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt};
        newp2 = m_mem[m_p1_addr];
        if (ln[0]) m_mem[acc][8:0] = wdata[8:0];
        if (ln[1]) m_mem[acc][17:9] = wdata[17:9];
        m_p2_en = m_p1_en;
        m_p2_data = newp2;
        m_p1_en = (o == 3'd1) || (cont_like && f_wfn() == 2'b00);
        m_p1_dsel = (o == 3'd0);
        m_p1_addr = acc;
        if (o == 3'd1 || o == 3'd2) m_act = 1'b1;
        else if (o == 3'd0) m_act = 1'b0;
    endtask

    // Checks every visible output against the reference, then crosses one edge.
    task automatic tick();
        logic drv;
        logic [DW-1:0] dat, edat;
        logic een;
        #1;
        drv = flow_mode ? (m_p1_en || (m_p1_dsel && m_p2_en)) : m_p2_en;
        dat = flow_mode ? (m_p1_en ? m_mem[m_p1_addr] : m_p2_data) : m_p2_data;
        een = drv && !oe_n;
        edat = een ? dat : '0;
        check(cyc_op === f_op(), "R1 R2 R3 R5 cyc_op", 32'(cyc_op), 32'(f_op()));
        check(wr_lane === f_lane(), "R4 R5 R10 wr_lane", 32'(wr_lane), 32'(f_lane()));
        check(bus_en === een, "R7 R8 R9 R10 bus_en", 32'(bus_en), 32'(een));
        check(bus_data === edat, "R5 R6 R7 bus_data", 32'(bus_data), 32'(edat));
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_in();
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
        cpu_start_n = 1'b1; ctl_start_n = 1'b1; adv_n = 1'b1;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 2'b11; oe_n = 1'b0;
    endtask

    task automatic do_desel();
        idle_in(); en_a_n = 1'b1; ctl_start_n = 1'b0; tick();
    endtask

    task automatic do_cpu(input logic [AW-1:0] a);
        idle_in(); cpu_start_n = 1'b0; wr_all_n = 1'b0; addr = a; tick();
    endtask

    task automatic do_ctl_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle_in(); ctl_start_n = 1'b0; wr_all_n = 1'b0; addr = a; wdata = d; tick();
    endtask

    task automatic do_beat(input logic adv, input logic [1:0] lanes, input logic [DW-1:0] d);
        idle_in(); adv_n = adv; wr_byte_n = (lanes == 2'b00); lane_sel_n = ~lanes;
        wdata = d; tick();
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED1));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        model_reset();
        idle_in(); addr = '0; wdata = '0; flow_mode = 1'b1; lin_order = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(bus_en === 1'b0, "R11 reset bus_en", 32'(bus_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: continue after reset must not access anything
        do_beat(1'b0, 2'b11, 18'h3FFFF);
        #1 check(bus_en === 1'b0 && wr_lane === 2'b00, "R10 R11 no burst after reset", 32'({bus_en, wr_lane}), 0);

        for (int i = 0; i < DEPTH; i++) do_ctl_write(AW'(i), pat(i));

        // R2: processor strobe with global write low still reads
        do_cpu(6'd4);
        #1 check(bus_en === 1'b1 && bus_data === pat(4), "R2 R7 flow read latency", 32'(bus_data), 32'(pat(4)));
        // R5: write in the suspend cycle after a processor start
        do_beat(1'b1, 2'b10, 18'h155AA);
        do_cpu(6'd4);
        #1 check(bus_data === {9'h0AA, pat(4)[8:0]}, "R5 R4 lane write after cpu start", 32'(bus_data), 32'({9'h0AA, pat(4)[8:0]}));
        // R8 flow-through: deselect keeps the word one more cycle
        do_desel();
        #1 check(bus_en === 1'b1, "R8 flow hold after deselect", 32'(bus_en), 1);
        do_desel();
        #1 check(bus_en === 1'b0, "R8 flow off after second edge", 32'(bus_en), 0);
        // R10: continue after deselect does nothing
        do_beat(1'b0, 2'b11, 18'h0);
        #1 check(bus_en === 1'b0, "R10 continue while idle", 32'(bus_en), 0);

        // R6: burst order from base 1
        lin_order = 1'b0;
        do_cpu(6'd9);
        do_beat(1'b0, 2'b00, 18'h0);
        #1 check(bus_data === pat(8), "R6 interleaved second beat", 32'(bus_data), 32'(pat(8)));
        lin_order = 1'b1;
        do_cpu(6'd9);
        do_beat(1'b0, 2'b00, 18'h0);
        #1 check(bus_data === pat(10), "R6 linear second beat", 32'(bus_data), 32'(pat(10)));

        // R7 and R8 in registered mode
        flow_mode = 1'b0;
        do_desel(); do_desel();
        do_cpu(6'd20);
        #1 check(bus_en === 1'b0, "R7 pipe no data after first edge", 32'(bus_en), 0);
        do_desel();
        #1 check(bus_en === 1'b1 && bus_data === pat(20), "R7 pipe data after second edge", 32'(bus_data), 32'(pat(20)));
        do_desel();
        #1 check(bus_en === 1'b0, "R8 pipe off", 32'(bus_en), 0);
        // R9: output enable acts without a clock
        do_cpu(6'd21); do_beat(1'b1, 2'b00, 18'h0);
        oe_n = 1'b1; #1 check(bus_en === 1'b0, "R9 oe_n high", 32'(bus_en), 0);
        oe_n = 1'b0; #1 check(bus_en === 1'b1, "R9 oe_n low", 32'(bus_en), 1);
        @(negedge clk);

        for (int k = 0; k < 3000; k++) begin
            if (k % 500 == 0) begin flow_mode = $urandom % 2; lin_order = $urandom % 2; end
            en_a_n = ($urandom % 8) == 0;
            en_b = ($urandom % 8) != 0;
            en_c_n = ($urandom % 8) == 0;
            cpu_start_n = ($urandom % 4) != 0;
            ctl_start_n = ($urandom % 3) != 0;
            adv_n = $urandom % 2;
            wr_all_n = ($urandom % 4) != 0;
            wr_byte_n = $urandom % 2;
            lane_sel_n = 2'($urandom);
            oe_n = ($urandom % 6) == 0;
            addr = AW'($urandom);
            wdata = DW'($urandom);
            tick();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule